// File: doc/BRIEF.md
# Member and Guest Entrance Gate Controller

This block decides when an entrance gate opens. It watches four inputs, all synchronous to the clock: a member-card pulse, a guest-request pulse, a coin-token pulse and a flag from an external timer that reports that the follow-on window has run out. It drives one open strobe.

A member always gets in at once. After a member admission, the window timer runs. A guest who asks while the window is still open pays one token. A guest who arrives alone, or after the window has closed, pays two tokens. The open strobe is a Mealy output, so it depends on both the current state and the inputs. It is asserted in the same cycle as the input that earns it.

The block has six states, held in a 3-bit register:

- `ST_IDLE` (0): nobody is being admitted.
- `ST_MEMBER` (1): a member was just admitted.
- `ST_WAITG` (2): a member was admitted earlier and the window is still open.
- `ST_FOLLOW` (3): a guest has followed a member in time and owes one token.
- `ST_GUEST` (4): a guest owes two tokens and none has been paid yet.
- `ST_TOKEN2` (5): a guest owes two tokens and has paid the first.

The two unused codes, 6 and 7, go back to `ST_IDLE` on the next clock with the gate closed.

Top module: `gate_admit_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `ST_IDLE`. After reset, a cycle with no inputs keeps the gate closed.
- R2: In `ST_IDLE`, a member pulse without a guest pulse raises `open_o` in that cycle and moves to `ST_MEMBER`.
- R3: In `ST_IDLE`, a guest pulse without a member pulse moves to `ST_GUEST` with `open_o` low.
- R4: `ST_MEMBER` and `ST_WAITG` share the same transitions:
  - A member pulse raises `open_o` and moves to `ST_MEMBER`.
  - With no pulse and `expired_i` low, the state moves to `ST_WAITG`.
  - With no pulse and `expired_i` high, the state moves to `ST_IDLE`.
- R5: In `ST_MEMBER` or `ST_WAITG`, a guest pulse with `expired_i` low moves to `ST_FOLLOW`. In `ST_FOLLOW`, the state holds with the gate closed until a token arrives. A token raises `open_o` and returns to `ST_IDLE`.
- R6: In `ST_MEMBER` or `ST_WAITG`, a guest pulse with `expired_i` high moves to `ST_GUEST`, so the guest pays two tokens.
- R7: In `ST_GUEST`, a token moves to `ST_TOKEN2` with `open_o` low. In `ST_TOKEN2`, a token raises `open_o` and returns to `ST_IDLE`. Without a token, each of these states holds.
- R8: `open_o` is high only in a cycle that has a qualifying member or token pulse. It is never high in any other cycle.
- R9: A member pulse and a guest pulse in the same cycle is illegal in every state. In that cycle `open_o` is low and the state is kept.
- R10: Inputs with no meaning in the current state are ignored:
  - `token_i` in `ST_IDLE`, `ST_MEMBER` and `ST_WAITG`.
  - A lone member or guest pulse in `ST_FOLLOW`, `ST_GUEST` and `ST_TOKEN2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| member_i | input | 1 | Member card pulse |
| guest_i | input | 1 | Guest request pulse |
| token_i | input | 1 | Coin token pulse |
| expired_i | input | 1 | High when the follow-on window has run out |
| open_o | output | 1 | Gate open strobe (Mealy) |

## Verification
`open_o` is combinational, so it is due in the same cycle as the stimulus. The bench drives the inputs on the falling edge and samples `open_o` 1 ns later, before the next rising edge. State changes appear one rising edge later. The bench never reads state directly. A bench reference model advances its own state at each rising edge, and every following cycle's sampled `open_o` exposes any state divergence at the ports.

// File: rtl/gate_admit_pkg.sv
`timescale 1ns/1ps
package gate_admit_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_MEMBER = 3'd1,
        ST_WAITG  = 3'd2,
        ST_FOLLOW = 3'd3,
        ST_GUEST  = 3'd4,
        ST_TOKEN2 = 3'd5
    } state_t;
endpackage

// File: rtl/gate_admit_next.sv
`timescale 1ns/1ps
module gate_admit_next
    import gate_admit_pkg::*;
(
    input  state_t state_q,
    input  logic   member_i,
    input  logic   guest_i,
    input  logic   token_i,
    input  logic   expired_i,
    output state_t state_d,
    output logic   open_o
);
    logic illegal;
    logic only_member;
    logic only_guest;

    assign illegal     = member_i & guest_i;
    assign only_member = member_i & ~guest_i;
    assign only_guest  = guest_i & ~member_i;

    // Next-state process
    always_comb begin
        state_d = state_q;
        if (!illegal) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (only_member)     state_d = ST_MEMBER;
                    else if (only_guest) state_d = ST_GUEST;
                end
                ST_MEMBER, ST_WAITG: begin
                    if (only_member)     state_d = ST_MEMBER;
                    else if (only_guest) state_d = expired_i ? ST_GUEST : ST_FOLLOW;
                    else                 state_d = expired_i ? ST_IDLE : ST_WAITG;
                end
                ST_FOLLOW: begin
                    if (token_i) state_d = ST_IDLE;
                end
                ST_GUEST: begin
                    if (token_i) state_d = ST_TOKEN2;
                end
                ST_TOKEN2: begin
                    if (token_i) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end else if (state_q != ST_IDLE   && state_q != ST_MEMBER &&
                     state_q != ST_WAITG  && state_q != ST_FOLLOW &&
                     state_q != ST_GUEST  && state_q != ST_TOKEN2) begin
            // Unused codes recover to idle even on an illegal cycle
            state_d = ST_IDLE;
        end
    end

    // Mealy output process
    always_comb begin
        open_o = 1'b0;
        if (!illegal) begin
            unique case (state_q)
                ST_IDLE, ST_MEMBER, ST_WAITG: open_o = only_member;
                ST_FOLLOW, ST_TOKEN2:         open_o = token_i;
                ST_GUEST:                     open_o = 1'b0;
                default:                      open_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gate_admit_state_reg.sv
`timescale 1ns/1ps
module gate_admit_state_reg
    import gate_admit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_t state_d,
    output state_t state_q
);
    // State register process
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/gate_admit_ctrl.sv
`timescale 1ns/1ps
module gate_admit_ctrl
    import gate_admit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic member_i,
    input  logic guest_i,
    input  logic token_i,
    input  logic expired_i,
    output logic open_o
);
    state_t state_q;
    state_t state_d;

    gate_admit_state_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .state_q (state_q)
    );

    gate_admit_next u_next (
        .state_q   (state_q),
        .member_i  (member_i),
        .guest_i   (guest_i),
        .token_i   (token_i),
        .expired_i (expired_i),
        .state_d   (state_d),
        .open_o    (open_o)
    );
endmodule

// File: rtl/gate_admit_chk.sv
`timescale 1ns/1ps
module gate_admit_chk
    import gate_admit_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   member_i,
    input logic   guest_i,
    input logic   token_i,
    input logic   expired_i,
    input logic   open_o,
    input state_t state_q
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> state_q == ST_IDLE); // R1

    AST_IDLE_MEMBER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && member_i && !guest_i) |-> open_o ##1 state_q == ST_MEMBER); // R2

    AST_IDLE_GUEST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && guest_i && !member_i) |-> !open_o ##1 state_q == ST_GUEST); // R3

    AST_WINDOW_LAPSE: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_MEMBER || state_q == ST_WAITG) && !member_i && !guest_i && expired_i)
        |=> state_q == ST_IDLE); // R4

    AST_FOLLOW_TOKEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FOLLOW && token_i && !(member_i && guest_i)) |-> open_o); // R5

    AST_LATE_GUEST: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_MEMBER || state_q == ST_WAITG) && guest_i && !member_i && expired_i)
        |=> state_q == ST_GUEST); // R6

    AST_FIRST_TOKEN_SHUT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GUEST) |-> !open_o); // R7

    AST_OPEN_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        open_o |-> (member_i || token_i)); // R8

    AST_ILLEGAL_SHUT: assert property (@(posedge clk) disable iff (rst)
        (member_i && guest_i) |-> !open_o); // R9

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (member_i && guest_i && state_q inside {ST_IDLE, ST_MEMBER, ST_WAITG,
                                                 ST_FOLLOW, ST_GUEST, ST_TOKEN2})
        |=> $stable(state_q)); // R9

    AST_IDLE_TOKEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !member_i && !guest_i && token_i)
        |-> !open_o ##1 state_q == ST_IDLE); // R10
endmodule

bind gate_admit_ctrl gate_admit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .member_i  (member_i),
    .guest_i   (guest_i),
    .token_i   (token_i),
    .expired_i (expired_i),
    .open_o    (open_o),
    .state_q   (state_q)
);

// File: tb/tb_gate_admit_ctrl.sv
`timescale 1ns/1ps
module tb_gate_admit_ctrl;
    localparam int IDLE = 0, MEMB = 1, WAITG = 2, FOLL = 3, GST = 4, TOK2 = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic member_i = 1'b0, guest_i = 1'b0, token_i = 1'b0, expired_i = 1'b0;
    logic open_o;
    int   checks = 0, failures = 0;
    int   mstate = IDLE;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    gate_admit_ctrl dut (
        .clk(clk), .rst(rst), .member_i(member_i), .guest_i(guest_i),
        .token_i(token_i), .expired_i(expired_i), .open_o(open_o)
    );

    // Reference model written from the requirements
    function automatic void ref_step(input int st, input bit m, input bit g,
                                     input bit t, input bit e,
                                     output int nst, output bit op);
        nst = st;
        op  = 1'b0;
        if (m && g) return;
        case (st)
            IDLE: begin
                if (m) begin nst = MEMB; op = 1'b1; end
                else if (g) nst = GST;
            end
            MEMB, WAITG: begin
                if (m) begin nst = MEMB; op = 1'b1; end
                else if (g) nst = e ? GST : FOLL;
                else nst = e ? IDLE : WAITG;
            end
            FOLL: if (t) begin nst = IDLE; op = 1'b1; end
            GST:  if (t) nst = TOK2;
            TOK2: if (t) begin nst = IDLE; op = 1'b1; end
            default: nst = IDLE;
        endcase
    endfunction

    task automatic step(input bit m, input bit g, input bit t, input bit e,
                        input string req);
        int nst;
        bit exp_open;
        @(negedge clk);
        member_i = m; guest_i = g; token_i = t; expired_i = e;
        #1;
        ref_step(mstate, m, g, t, e, nst, exp_open);
        checks++;
        if (open_o !== exp_open) begin
            failures++;
            $display("FAIL %s: open_o actual=%b expected=%b (model state %0d, in m%b g%b t%b e%b)",
                     req, open_o, exp_open, mstate, m, g, t, e);
        end
        @(posedge clk);
        mstate = nst;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        member_i = 0; guest_i = 0; token_i = 0; expired_i = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mstate = IDLE;
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        do_reset();
        // R1: reset leaves the gate closed and the state idle
        step(0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, "R1");
        // R2, R4: member admission, then the window holds and lapses
        do_reset();
        step(1, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, "R4");
        step(0, 0, 1, 0, "R10");
        step(0, 0, 0, 0, "R10");
        // R5, R9, R10: a guest following a member pays one token
        step(1, 0, 0, 0, "R2");
        step(0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, "R5");
        step(1, 1, 1, 0, "R9");
        step(1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, "R10");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, "R10");
        // R6: a guest after the window has lapsed pays two tokens
        step(1, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R4");
        step(0, 1, 0, 1, "R6");
        step(0, 0, 1, 0, "R6");
        step(0, 0, 1, 0, "R6");
        // R3, R7, R8: a lone guest pays two tokens
        step(0, 1, 0, 0, "R3");
        step(1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 1, 0, "R7");
        step(0, 1, 0, 0, "R10");
        step(1, 1, 1, 0, "R9");
        step(0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, "R8");
        // R9: an illegal cycle in idle and in a member state
        step(1, 1, 0, 0, "R9");
        step(0, 0, 1, 0, "R9");
        step(1, 0, 0, 0, "R2");
        step(1, 1, 0, 1, "R9");
        step(0, 1, 0, 0, "R9");
        step(0, 0, 1, 0, "R5");
        // R8: constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit m, g, t, e;
            m = ($urandom % 6) == 0;
            g = ($urandom % 6) == 0;
            t = ($urandom % 4) == 0;
            e = ($urandom % 3) == 0;
            step(m, g, t, e, "R8");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule